// File: doc/BRIEF.md
# Predicated Element-Serial Vector Lane

This block is a single-lane integer vector execution unit. It accepts one decoded vector instruction at a time through a valid/ready handshake. It then steps one arithmetic unit through the elements of a small register file, one element per cycle. The vector length is sampled with the instruction and sets how many elements, counted from index 0, the instruction touches. Elements at higher indices keep their old contents.

Each instruction may carry a guard that names one predicate register. An optional negation selects whether a set bit or a clear bit enables the element. A compare-against-zero instruction writes predicate bits, so later instructions can act on only part of a vector. Every element step is visible on a result bus that shows the element index, whether it was written, and the value. A one-cycle done pulse marks the end of each instruction.

Top module: `vec_lane`

## Requirements
- R1: After reset, in_ready_o is 1 and done_o and res_valid_o are 0. All vector elements and all predicate bits are 0.
- R2: An instruction is taken only on a clock edge where in_valid_i and in_ready_o are both 1. For the next VL cycles, res_valid_o is 1 and in_ready_o is 0, and res_idx_o counts 0, 1, ... VL-1, one step per cycle.
- R3: The effective VL is vl_i clamped to the element count (8). Any vl_i above 8 processes exactly 8 elements.
- R4: done_o is a one-cycle pulse in the cycle after element VL-1 appears on the result bus, and in_ready_o is 1 in that cycle. With VL=0, done_o pulses in the cycle after acceptance, res_valid_o stays 0, and nothing is written.
- R5: op 0 (add) writes vd[i] = vs1[i] + vs2[i] modulo 2^16.
- R6: op 1 (multiply-add) writes vd[i] = sa_i * vs1[i] + vs2[i] modulo 2^16. The scalar operand is sampled at acceptance.
- R7: op 2 (move) writes vd[i] = vs1[i].
- R8: op 3 (index ramp) writes vd[i] = sa_i + i * sb_i modulo 2^16.
- R9: op 4 (compare to zero) sets predicate bit pd[i] to 1 when vs1[i] == 0 and to 0 otherwise. It shows the bit in res_data_o bit 0. Bits at index VL or higher are left unchanged.
- R10: When guard_en_i is 1, element i is written only if predicate bit guard_sel[i] differs from guard_neg_i. A set bit enables the element when not negated, and a clear bit enables it when negated. res_wen_o is 1 exactly for written elements, and elements that are not written keep their value.
- R11: Elements at index VL or higher of the destination are left unchanged.
- R12: op codes 5, 6 and 7 still step through VL elements and pulse done_o. They write no element and keep res_wen_o at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Instruction offered |
| in_ready_o | output | 1 | Lane idle, instruction can be taken |
| op_i | input | 3 | Operation code |
| vd_i | input | 2 | Destination vector register |
| vs1_i | input | 2 | First source vector register |
| vs2_i | input | 2 | Second source vector register |
| pd_i | input | 1 | Destination predicate register for compare |
| guard_en_i | input | 1 | Enable predicate guard |
| guard_sel_i | input | 1 | Guarding predicate register |
| guard_neg_i | input | 1 | Guard on clear bits instead of set bits |
| vl_i | input | 4 | Requested vector length |
| sa_i | input | 16 | Scalar operand a |
| sb_i | input | 16 | Scalar operand b (ramp stride) |
| res_valid_o | output | 1 | An element is being processed this cycle |
| res_wen_o | output | 1 | This element is written |
| res_idx_o | output | 3 | Element index |
| res_data_o | output | 16 | Element result |
| done_o | output | 1 | Instruction finished pulse |

## Verification
The bench sweeps the vector length from 0 past the element count. A sequencer with an off-by-one end condition would show one element too many or too few, or would drop the done pulse at length zero. A missing clamp would run beyond element 7. After every short-length instruction, the whole register is read back through a self-move. This catches a lane that writes tail elements or clobbers predicate bits beyond the length. All four guard combinations are applied to mixed predicate patterns, and the multiply-add and ramp use operands that overflow 16 bits. An inverted negate, a wrong predicate select, or a wrong wrap would therefore corrupt specific elements. Undefined op codes are issued to confirm that they write nothing and still end.

// File: rtl/lane_pkg.sv
package lane_pkg;
  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_MADD = 3'd1,
    OP_MOVE = 3'd2,
    OP_IOTA = 3'd3,
    OP_CMPZ = 3'd4
  } lane_op_e;
endpackage

// File: rtl/lane_seq.sv
module lane_seq #(
  parameter int NELEM = 8,
  parameter int IW    = $clog2(NELEM),
  parameter int LW    = $clog2(NELEM + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [LW-1:0] vl_i,
  output logic          busy_o,
  output logic [IW-1:0] idx_o,
  output logic          done_o
);
  logic          busy_q, done_q;
  logic [IW-1:0] idx_q;
  logic [LW-1:0] vl_q, vl_eff;

  assign vl_eff = (vl_i > LW'(NELEM)) ? LW'(NELEM) : vl_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      idx_q  <= '0;
      vl_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        idx_q <= '0;
        vl_q  <= vl_eff;
        if (vl_eff == '0) done_q <= 1'b1;
        else              busy_q <= 1'b1;
      end else if (busy_q) begin
        if (LW'(idx_q) == vl_q - LW'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          idx_q <= idx_q + IW'(1);
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign idx_o  = idx_q;
  assign done_o = done_q;

  a_r3_idx_below_vl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (LW'(idx_q) < vl_q && vl_q <= LW'(NELEM)));
endmodule

// File: rtl/lane_alu.sv
module lane_alu
  import lane_pkg::*;
#(
  parameter int DW = 16,
  parameter int IW = 3
) (
  input  logic [2:0]    op_i,
  input  logic [DW-1:0] x_i,
  input  logic [DW-1:0] y_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic [IW-1:0] idx_i,
  output logic [DW-1:0] res_o,
  output logic          legal_o,
  output logic          pred_o
);
  always_comb begin
    res_o   = '0;
    legal_o = 1'b1;
    pred_o  = 1'b0;
    case (op_i)
      OP_ADD:  res_o = x_i + y_i;
      OP_MADD: res_o = a_i * x_i + y_i;
      OP_MOVE: res_o = x_i;
      OP_IOTA: res_o = a_i + b_i * DW'(idx_i);
      OP_CMPZ: begin
        res_o  = {{(DW-1){1'b0}}, (x_i == '0)};
        pred_o = 1'b1;
      end
      default: legal_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/lane_vrf.sv
module lane_vrf #(
  parameter int NREG  = 4,
  parameter int NELEM = 8,
  parameter int DW    = 16,
  parameter int RW    = $clog2(NREG),
  parameter int IW    = $clog2(NELEM)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [IW-1:0] idx_i,
  input  logic [RW-1:0] ra1_i,
  input  logic [RW-1:0] ra2_i,
  output logic [DW-1:0] rd1_o,
  output logic [DW-1:0] rd2_o,
  input  logic          we_i,
  input  logic [RW-1:0] wa_i,
  input  logic [DW-1:0] wd_i
);
  logic [NREG-1:0][NELEM-1:0][DW-1:0] all_w;

  for (genvar g = 0; g < NREG; g++) begin : gen_reg
    logic [NELEM-1:0][DW-1:0] row_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         row_q <= '0;
      else if (we_i && wa_i == RW'(g))     row_q[idx_i] <= wd_i;
    end
    assign all_w[g] = row_q;
  end

  assign rd1_o = all_w[ra1_i][idx_i];
  assign rd2_o = all_w[ra2_i][idx_i];

  a_r11_elem_written: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(we_i) |-> all_w[$past(wa_i)][$past(idx_i)] == $past(wd_i));
endmodule

// File: rtl/lane_prf.sv
module lane_prf #(
  parameter int NPRED = 2,
  parameter int NELEM = 8,
  parameter int PW    = $clog2(NPRED),
  parameter int IW    = $clog2(NELEM)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [IW-1:0] idx_i,
  input  logic [PW-1:0] rs_i,
  output logic          rd_o,
  input  logic          we_i,
  input  logic [PW-1:0] wa_i,
  input  logic          wd_i
);
  logic [NPRED-1:0][NELEM-1:0] p_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   p_q <= '0;
    else if (we_i) p_q[wa_i][idx_i] <= wd_i;
  end

  assign rd_o = p_q[rs_i][idx_i];

  a_r9_pred_written: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(we_i) |-> p_q[$past(wa_i)][$past(idx_i)] == $past(wd_i));
endmodule

// File: rtl/vec_lane.sv
module vec_lane #(
  parameter int NREG  = 4,
  parameter int NELEM = 8,
  parameter int DW    = 16,
  parameter int NPRED = 2,
  localparam int RW   = $clog2(NREG),
  localparam int IW   = $clog2(NELEM),
  localparam int LW   = $clog2(NELEM + 1),
  localparam int PW   = $clog2(NPRED)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_valid_i,
  output logic          in_ready_o,
  input  logic [2:0]    op_i,
  input  logic [RW-1:0] vd_i,
  input  logic [RW-1:0] vs1_i,
  input  logic [RW-1:0] vs2_i,
  input  logic [PW-1:0] pd_i,
  input  logic          guard_en_i,
  input  logic [PW-1:0] guard_sel_i,
  input  logic          guard_neg_i,
  input  logic [LW-1:0] vl_i,
  input  logic [DW-1:0] sa_i,
  input  logic [DW-1:0] sb_i,
  output logic          res_valid_o,
  output logic          res_wen_o,
  output logic [IW-1:0] res_idx_o,
  output logic [DW-1:0] res_data_o,
  output logic          done_o
);
  logic          accept, busy, gbit, pass, legal, is_pred, wen;
  logic [IW-1:0] idx;
  logic [DW-1:0] x, y, res;

  logic [2:0]    op_q;
  logic [RW-1:0] vd_q, vs1_q, vs2_q;
  logic [PW-1:0] pd_q, gsel_q;
  logic          gen_q, gneg_q;
  logic [DW-1:0] sa_q, sb_q;

  assign in_ready_o = !busy;
  assign accept     = in_valid_i && in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q <= '0; vd_q <= '0; vs1_q <= '0; vs2_q <= '0;
      pd_q <= '0; gsel_q <= '0; gen_q <= 1'b0; gneg_q <= 1'b0;
      sa_q <= '0; sb_q <= '0;
    end else if (accept) begin
      op_q <= op_i; vd_q <= vd_i; vs1_q <= vs1_i; vs2_q <= vs2_i;
      pd_q <= pd_i; gsel_q <= guard_sel_i; gen_q <= guard_en_i; gneg_q <= guard_neg_i;
      sa_q <= sa_i; sb_q <= sb_i;
    end
  end

  lane_seq #(.NELEM(NELEM), .IW(IW), .LW(LW)) u_seq (
    .clk_i, .rst_ni, .start_i(accept), .vl_i,
    .busy_o(busy), .idx_o(idx), .done_o
  );

  lane_vrf #(.NREG(NREG), .NELEM(NELEM), .DW(DW), .RW(RW), .IW(IW)) u_vrf (
    .clk_i, .rst_ni, .idx_i(idx),
    .ra1_i(vs1_q), .ra2_i(vs2_q), .rd1_o(x), .rd2_o(y),
    .we_i(wen && !is_pred), .wa_i(vd_q), .wd_i(res)
  );

  lane_prf #(.NPRED(NPRED), .NELEM(NELEM), .PW(PW), .IW(IW)) u_prf (
    .clk_i, .rst_ni, .idx_i(idx), .rs_i(gsel_q), .rd_o(gbit),
    .we_i(wen && is_pred), .wa_i(pd_q), .wd_i(res[0])
  );

  lane_alu #(.DW(DW), .IW(IW)) u_alu (
    .op_i(op_q), .x_i(x), .y_i(y), .a_i(sa_q), .b_i(sb_q), .idx_i(idx),
    .res_o(res), .legal_o(legal), .pred_o(is_pred)
  );

  // guard passes on a set bit, or on a clear bit when negated
  assign pass = !gen_q || (gbit != gneg_q);
  assign wen  = busy && pass && legal;

  assign res_valid_o = busy;
  assign res_wen_o   = wen;
  assign res_idx_o   = idx;
  assign res_data_o  = res;

  a_r2_idx_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && $past(res_valid_o)) |-> res_idx_o == $past(res_idx_o) + IW'(1));
  a_r2_first_idx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(accept) |-> (res_idx_o == '0 && !in_ready_o) || done_o);
  a_r4_done_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(res_valid_o) && !res_valid_o) |-> (done_o && in_ready_o));
endmodule

// File: tb/tb_vec_lane.sv
module tb_vec_lane;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [2:0] op = '0;
  logic [1:0] vd = '0, vs1 = '0, vs2 = '0;
  logic pd = 1'b0, gen = 1'b0, gsel = 1'b0, gneg = 1'b0;
  logic [3:0] vl = '0;
  logic [15:0] sa = '0, sb = '0;
  logic res_valid, res_wen, done;
  logic [2:0] res_idx;
  logic [15:0] res_data;

  int checks = 0, failures = 0;
  logic [15:0] m_reg [4][8];
  logic        m_pred [2][8];

  always #10 clk = ~clk;

  vec_lane dut (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .op_i(op), .vd_i(vd), .vs1_i(vs1), .vs2_i(vs2), .pd_i(pd),
    .guard_en_i(gen), .guard_sel_i(gsel), .guard_neg_i(gneg), .vl_i(vl),
    .sa_i(sa), .sb_i(sb), .res_valid_o(res_valid), .res_wen_o(res_wen),
    .res_idx_o(res_idx), .res_data_o(res_data), .done_o(done)
  );

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic run(input int o, input int d, input int s1, input int s2, input int p,
                     input int ge, input int gs, input int gn, input int l,
                     input logic [15:0] a, input logic [15:0] b, input string tag);
    int ve;
    ve = (l > 8) ? 8 : l;
    @(negedge clk);
    op = 3'(o); vd = 2'(d); vs1 = 2'(s1); vs2 = 2'(s2); pd = 1'(p);
    gen = 1'(ge); gsel = 1'(gs); gneg = 1'(gn); vl = 4'(l); sa = a; sb = b;
    in_valid = 1'b1;
    for (int k = 0; k <= ve; k++) begin
      logic [15:0] x, y, e;
      logic pass, w;
      @(negedge clk);
      if (k == 0) in_valid = 1'b0;
      if (k < ve) begin
        x = m_reg[s1][k]; y = m_reg[s2][k];
        case (o)
          0: e = x + y;
          1: e = a * x + y;
          2: e = x;
          3: e = a + b * 16'(k);
          4: e = {15'b0, x == 16'h0};
          default: e = '0;
        endcase
        pass = (ge == 0) || (m_pred[gs][k] != 1'(gn));
        w = pass && (o <= 4);
        chk({res_valid, res_idx, res_wen, in_ready, done} == {1'b1, 3'(k), w, 1'b0, 1'b0},
            $sformatf("R2/R10 %s elem %0d ctl", tag, k),
            {res_valid, res_idx, res_wen, in_ready, done}, {1'b1, 3'(k), w, 1'b0, 1'b0});
        if (w) begin
          chk(res_data == e, $sformatf("%s elem %0d data", tag, k), res_data, e);
          if (o == 4) m_pred[p][k] = e[0];
          else        m_reg[d][k] = e;
        end
      end else begin
        chk({done, res_valid, in_ready} == 3'b101, $sformatf("R4 %s done", tag),
            {done, res_valid, in_ready}, 3'b101);
      end
    end
  endtask

  // self-move reads back a register without changing it
  task automatic dump(input int r, input string tag);
    run(2, r, r, 0, 0, 0, 0, 0, 8, 16'h0, 16'h0, tag);
  endtask

  // guarded self-move reveals predicate bits through res_wen_o
  task automatic dump_pred(input int p, input string tag);
    run(2, 0, 0, 0, 0, 1, p, 0, 8, 16'h0, 16'h0, tag);
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        failures++;
        $display("FAIL watchdog R2 act=%0d exp=%0d", cyc, 100000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    for (int r = 0; r < 4; r++) for (int k = 0; k < 8; k++) m_reg[r][k] = '0;
    for (int p = 0; p < 2; p++) for (int k = 0; k < 8; k++) m_pred[p][k] = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({in_ready, done, res_valid} == 3'b100, "R1 reset outputs", {in_ready, done, res_valid}, 3'b100);
    for (int r = 0; r < 4; r++) dump(r, "R1 reset reg");
    dump_pred(0, "R1 reset pred0");
    dump_pred(1, "R1 reset pred1");

    run(3, 0, 0, 0, 0, 0, 0, 0, 8, 16'd5, 16'd3, "R8 ramp");
    run(3, 1, 0, 0, 0, 0, 0, 0, 8, 16'hFFF0, 16'h2101, "R8 ramp wrap");
    run(0, 2, 0, 1, 0, 0, 0, 0, 8, 16'h0, 16'h0, "R5 add");
    run(1, 3, 0, 1, 0, 0, 0, 0, 8, 16'h1234, 16'h0, "R6 madd");
    run(1, 3, 1, 3, 0, 0, 0, 0, 8, 16'hFFFF, 16'h0, "R6 madd wrap");
    run(2, 2, 3, 0, 0, 0, 0, 0, 5, 16'h0, 16'h0, "R7 move short");
    dump(2, "R11 tail after short move");

    run(3, 1, 0, 0, 0, 0, 0, 0, 8, 16'hFFFD, 16'd1, "R8 ramp through zero");
    run(4, 0, 1, 0, 0, 0, 0, 0, 8, 16'h0, 16'h0, "R9 cmpz p0");
    run(3, 2, 0, 0, 0, 0, 0, 0, 8, 16'h0, 16'h0, "R8 zeros");
    run(4, 0, 2, 0, 1, 0, 0, 0, 8, 16'h0, 16'h0, "R9 cmpz p1 all");
    run(3, 3, 0, 0, 0, 0, 0, 0, 8, 16'h0, 16'h8000, "R8 alt zeros");
    run(4, 0, 3, 0, 1, 0, 0, 0, 5, 16'h0, 16'h0, "R9 cmpz p1 short");
    dump_pred(0, "R9 readback p0");
    dump_pred(1, "R9 tail p1");

    run(0, 0, 0, 1, 0, 1, 1, 0, 8, 16'h0, 16'h0, "R10 add guard p1");
    run(1, 2, 1, 0, 0, 1, 0, 1, 8, 16'h0007, 16'h0, "R10 madd guard !p0");
    for (int gs = 0; gs < 2; gs++)
      for (int gn = 0; gn < 2; gn++) begin
        run(2, 3, gs, 0, 0, 1, gs, gn, 8, 16'h0, 16'h0, "R10 move guard");
        dump(3, "R10 unguarded left");
      end
    run(4, 0, 2, 0, 0, 1, 1, 1, 6, 16'h0, 16'h0, "R10 cmpz guard");
    dump_pred(0, "R10 pred after guarded cmpz");

    run(2, 1, 0, 0, 0, 0, 0, 0, 15, 16'h0, 16'h0, "R3 vl clamp 15");
    run(3, 2, 0, 0, 0, 0, 0, 0, 9, 16'h0100, 16'h0011, "R3 vl clamp 9");
    run(2, 1, 2, 0, 0, 0, 0, 0, 0, 16'h0, 16'h0, "R4 vl zero");
    dump(1, "R4 nothing written at vl zero");
    run(4, 0, 0, 0, 0, 0, 0, 0, 0, 16'h0, 16'h0, "R4 vl zero cmpz");
    dump_pred(0, "R4 pred untouched");
    run(0, 3, 1, 2, 0, 0, 0, 0, 1, 16'h0, 16'h0, "R11 vl one");
    dump(3, "R11 vl one tail");

    for (int o = 5; o < 8; o++) begin
      run(o, 0, 1, 2, 0, 0, 0, 0, 8, 16'h1111, 16'h2222, "R12 undefined op");
      dump(0, "R12 no write");
    end
    run(5, 0, 1, 2, 0, 0, 0, 0, 0, 16'h0, 16'h0, "R12 undefined op vl zero");

    for (int l = 0; l <= 9; l++) begin
      run(3, 1, 0, 0, 0, 0, 0, 0, 8, 16'(l * 977), 16'(l * 4099 + 1), "R8 sweep seed");
      run(1, 0, 1, 0, 0, 0, 0, 0, l, 16'(l * 313 + 7), 16'h0, "R6 sweep");
      run(0, 2, 0, 1, 0, 0, 0, 0, l, 16'h0, 16'h0, "R5 sweep");
      dump(0, "R11 sweep tail v0");
      dump(2, "R11 sweep tail v2");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule